// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Engine

This block moves data between two regions of memory by following a list of transfer descriptors. Software puts a list of descriptors in memory, one after another, places the address of the first one on the base input and pulses start. The engine reads one descriptor, copies its data block one 32-bit word at a time from the card-side source address to the host-side destination address, and then goes on to the next descriptor. It stops after it finishes a descriptor that has its final-entry flag set. Every descriptor and data word is taken little-endian: byte 0 of a word is bits 7:0, and words pass through without any byte swapping.

A descriptor is three 32-bit words at consecutive addresses. Its control word carries an 18-bit byte count, which must be a non-zero multiple of 256, and a final-entry flag. A malformed descriptor, or a memory error, stops the engine and records the cause in a five-bit sticky status register. Software clears that register one bit at a time by writing ones. The interrupt output is asserted while the interrupt enable is set and any status bit is set.

The memory side is a simple request/response word port. The engine drives a request for exactly one cycle and then waits for a single response, which carries read data and an error flag. At most one access is in flight at any time.

Top module: `sgdma_engine`

## Requirements
- R1: A descriptor at address A is read as three words in the order A (source address), A+4 (destination address), A+8 (control word). When a descriptor without the final flag completes, the next descriptor is fetched from A+12.
- R2: Control word bits 17:0 are the byte count and bit 31 is the final flag. Bits 30:18 have no effect on the transfer.
- R3: A descriptor with byte count N moves N/4 words. For word k it reads source+4k and then writes the returned data unchanged to destination+4k, before it moves on to word k+1.
- R4: When a descriptor with the final flag completes, status bit 0 (read completed) and bit 1 (write completed) are set in the same cycle that busy drops. A descriptor without the flag never sets these bits.
- R5: A count of zero, or a count whose bits 7:0 are not all zero, sets status bit 4 (array error) and stops the engine with no data access. An error response to a descriptor fetch also sets bit 4 and stops the engine.
- R6: An error response to a data read sets status bit 2. An error response to a data write sets status bit 3. In both cases the engine stops and issues no further request.
- R7: A start pulse while idle begins a walk at the base input. A start pulse while busy is ignored: the request sequence and the final status stay unchanged.
- R8: Status bits are sticky. A clear pulse drops exactly the bits that are set in the clear mask and leaves all other bits unchanged.
- R9: The interrupt output is high exactly when the interrupt enable is high and at least one status bit is set.
- R10: Each request lasts one cycle, is issued only while busy, and is never followed by another request before its response arrives.
- R11: After reset the engine is idle, the status is zero, and there is no request and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start | input | 1 | Start pulse |
| sw_base | input | 32 | Address of the first descriptor |
| sw_clr | input | 1 | Status clear pulse |
| sw_clr_mask | input | 5 | Status bits to clear (write-one-to-clear) |
| irq_en | input | 1 | Interrupt enable |
| busy | output | 1 | Engine is walking a list |
| status | output | 5 | Sticky status: 0 rd done, 1 wr done, 2 rd err, 3 wr err, 4 array err |
| irq | output | 1 | Interrupt |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rsp | input | 1 | Response strobe |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rdata | input | 32 | Read data, valid with mem_rsp |

## Verification
The assertions rely on three rules for the memory port. The memory answers each request exactly once, at least one cycle after the request, and never sends a response that was not asked for. Start and clear arrive as single-cycle pulses. The bench memory model keeps to these rules: it holds one pending request, answers it after a latency chosen per test, and can inject an error at one address for either a read or a write. Source and destination regions never overlap, so the data the bench expects is fixed when the list is built.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
   localparam int STAT_W = 5;
   localparam int SB_RD_DONE = 0;
   localparam int SB_WR_DONE = 1;
   localparam int SB_RD_ERR  = 2;
   localparam int SB_WR_ERR  = 3;
   localparam int SB_ARR_ERR = 4;

   typedef enum logic [3:0] {
      ST_IDLE, ST_FREQ, ST_FWAIT, ST_CHECK,
      ST_RREQ, ST_RWAIT, ST_WREQ, ST_WWAIT
   } sg_state_e;
endpackage

// File: rtl/sgdma_desc_check.sv
module sgdma_desc_check #(
   parameter int CNT_W    = 18,
   parameter int BLK_LOG2 = 8,
   parameter int WSH      = 2
) (
   input  logic [CNT_W-1:0] count,
   output logic             bad,
   output logic [CNT_W-1:0] words
);
   localparam int CHK = (BLK_LOG2 < WSH) ? WSH : BLK_LOG2;

   always_comb begin
      bad   = (count == '0) || (|count[CHK-1:0]);
      words = count >> WSH;
   end
endmodule

// File: rtl/sgdma_status.sv
module sgdma_status #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_mask,
   input  logic         clr,
   input  logic [W-1:0] clr_mask,
   input  logic         irq_en,
   output logic [W-1:0] status,
   output logic         irq
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            status[i] <= 1'b0;
         else if (set_mask[i])
            status[i] <= 1'b1;
         else if (clr && clr_mask[i])
            status[i] <= 1'b0;
      end
   end

   assign irq = irq_en & (|status);
endmodule

// File: rtl/sgdma_core.sv
module sgdma_core import sgdma_pkg::*; #(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int CNT_W    = 18,
   parameter int LAST_BIT = 31,
   parameter int BLK_LOG2 = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [AW-1:0]     base,
   output logic              busy,
   output logic [STAT_W-1:0] set_mask,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic              mem_rsp,
   input  logic              mem_rsp_err,
   input  logic [DW-1:0]     mem_rdata
);
   localparam int STEP = DW / 8;
   localparam int WSH  = $clog2(STEP);

   sg_state_e        state;
   logic [AW-1:0]    fetch_ptr, src, dst;
   logic [CNT_W-1:0] cnt_q, remain, words;
   logic             last_q, bad;
   logic [1:0]       widx;
   logic [DW-1:0]    hold;

   sgdma_desc_check #(.CNT_W(CNT_W), .BLK_LOG2(BLK_LOG2), .WSH(WSH)) u_check (
      .count(cnt_q), .bad(bad), .words(words)
   );

   assign busy      = (state != ST_IDLE);
   assign mem_req   = (state == ST_FREQ) || (state == ST_RREQ) || (state == ST_WREQ);
   assign mem_we    = (state == ST_WREQ);
   assign mem_wdata = hold;

   always_comb begin
      unique case (state)
         ST_FREQ: mem_addr = fetch_ptr;
         ST_WREQ: mem_addr = dst;
         default: mem_addr = src;
      endcase
   end

   always_comb begin
      set_mask = '0;
      unique case (state)
         ST_FWAIT: if (mem_rsp && mem_rsp_err) set_mask[SB_ARR_ERR] = 1'b1;
         ST_CHECK: if (bad) set_mask[SB_ARR_ERR] = 1'b1;
         ST_RWAIT: if (mem_rsp && mem_rsp_err) set_mask[SB_RD_ERR] = 1'b1;
         ST_WWAIT: begin
            if (mem_rsp && mem_rsp_err)
               set_mask[SB_WR_ERR] = 1'b1;
            else if (mem_rsp && remain == CNT_W'(1) && last_q) begin
               set_mask[SB_RD_DONE] = 1'b1;
               set_mask[SB_WR_DONE] = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         fetch_ptr <= '0;
         src       <= '0;
         dst       <= '0;
         cnt_q     <= '0;
         last_q    <= 1'b0;
         widx      <= '0;
         remain    <= '0;
         hold      <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               fetch_ptr <= base;
               widx      <= '0;
               state     <= ST_FREQ;
            end
            ST_FREQ: state <= ST_FWAIT;
            ST_FWAIT: if (mem_rsp) begin
               if (mem_rsp_err) state <= ST_IDLE;
               else begin
                  fetch_ptr <= fetch_ptr + AW'(STEP);
                  unique case (widx)
                     2'd0:    src <= mem_rdata[AW-1:0];
                     2'd1:    dst <= mem_rdata[AW-1:0];
                     default: begin
                        cnt_q  <= mem_rdata[CNT_W-1:0];
                        last_q <= mem_rdata[LAST_BIT];
                     end
                  endcase
                  if (widx == 2'd2) begin
                     widx  <= '0;
                     state <= ST_CHECK;
                  end else begin
                     widx  <= widx + 2'd1;
                     state <= ST_FREQ;
                  end
               end
            end
            ST_CHECK: if (bad) state <= ST_IDLE;
               else begin
                  remain <= words;
                  state  <= ST_RREQ;
               end
            ST_RREQ: state <= ST_RWAIT;
            ST_RWAIT: if (mem_rsp) begin
               if (mem_rsp_err) state <= ST_IDLE;
               else begin
                  hold  <= mem_rdata;
                  state <= ST_WREQ;
               end
            end
            ST_WREQ: state <= ST_WWAIT;
            ST_WWAIT: if (mem_rsp) begin
               if (mem_rsp_err) state <= ST_IDLE;
               else begin
                  src <= src + AW'(STEP);
                  dst <= dst + AW'(STEP);
                  if (remain == CNT_W'(1))
                     state <= last_q ? ST_IDLE : ST_FREQ;
                  else begin
                     remain <= remain - CNT_W'(1);
                     state  <= ST_RREQ;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine import sgdma_pkg::*; #(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int CNT_W    = 18,
   parameter int LAST_BIT = 31,
   parameter int BLK_LOG2 = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_start,
   input  logic [AW-1:0]     sw_base,
   input  logic              sw_clr,
   input  logic [STAT_W-1:0] sw_clr_mask,
   input  logic              irq_en,
   output logic              busy,
   output logic [STAT_W-1:0] status,
   output logic              irq,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic              mem_rsp,
   input  logic              mem_rsp_err,
   input  logic [DW-1:0]     mem_rdata
);
   if (DW != 32) begin : g_bad_dw
      $error("sgdma_engine: descriptor layout needs DW of 32");
   end
   if (AW > DW) begin : g_bad_aw
      $error("sgdma_engine: an address must fit in one descriptor word");
   end
   if (LAST_BIT >= DW || CNT_W >= LAST_BIT) begin : g_bad_ctrl
      $error("sgdma_engine: count field and final flag overlap or exceed the word");
   end
   if (BLK_LOG2 >= CNT_W) begin : g_bad_blk
      $error("sgdma_engine: block granule wider than count field");
   end

   logic [STAT_W-1:0] set_mask;

   sgdma_core #(
      .AW(AW), .DW(DW), .CNT_W(CNT_W), .LAST_BIT(LAST_BIT), .BLK_LOG2(BLK_LOG2)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .start(sw_start), .base(sw_base),
      .busy(busy), .set_mask(set_mask),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rsp(mem_rsp), .mem_rsp_err(mem_rsp_err), .mem_rdata(mem_rdata)
   );

   sgdma_status #(.W(STAT_W)) u_status (
      .clk(clk), .rst_n(rst_n), .set_mask(set_mask),
      .clr(sw_clr), .clr_mask(sw_clr_mask), .irq_en(irq_en),
      .status(status), .irq(irq)
   );
endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sw_start,
   input logic       sw_clr,
   input logic [4:0] sw_clr_mask,
   input logic       irq_en,
   input logic       busy,
   input logic [4:0] status,
   input logic       irq,
   input logic       mem_req
);
   // R10
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R10
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   // R7
   start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(sw_start));

   // R4
   done_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[0]) |-> (!busy && $past(busy)));

   // R6
   err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(status[2]) || $rose(status[3])) |-> !busy);

   // R8
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(status) & ~status & ~$past(sw_clr ? sw_clr_mask : 5'd0)) == 5'd0));

   // R9
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> (!irq_en || $past(sw_clr)));
endmodule

bind sgdma_engine sgdma_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_clr(sw_clr),
   .sw_clr_mask(sw_clr_mask), .irq_en(irq_en), .busy(busy), .status(status),
   .irq(irq), .mem_req(mem_req)
);

// File: tb/sgdma_engine_bench.sv
module sgdma_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_start = 1'b0;
   logic [31:0] sw_base = '0;
   logic        sw_clr = 1'b0;
   logic [4:0]  sw_clr_mask = '0;
   logic        irq_en = 1'b1;
   logic        busy, irq, mem_req, mem_we;
   logic [4:0]  status;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_rsp = 1'b0, mem_rsp_err = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #5ns clk = ~clk;

   sgdma_engine u_sgdma_engine (
      .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_base(sw_base),
      .sw_clr(sw_clr), .sw_clr_mask(sw_clr_mask), .irq_en(irq_en),
      .busy(busy), .status(status), .irq(irq),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rsp(mem_rsp), .mem_rsp_err(mem_rsp_err), .mem_rdata(mem_rdata)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [31:0] mem [0:4095];
   logic [31:0] q_addr [$];
   logic        q_we   [$];
   logic [31:0] q_data [$];
   int          lat = 0;
   bit          err_on = 0;
   logic [31:0] err_a = '0;
   logic        err_w = 1'b0;
   bit          pend = 0;
   int          cnt = 0;
   logic [31:0] p_addr, p_data;
   logic        p_we;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic bit is_err(input logic [31:0] a, input logic w);
      return err_on && a == err_a && w == err_w;
   endfunction

   // behavioural memory and request monitor, evaluated every clock
   always @(negedge clk) begin
      mem_rsp = 1'b0;
      mem_rsp_err = 1'b0;
      if (pend) begin
         if (cnt == 0) begin
            mem_rsp = 1'b1;
            mem_rsp_err = is_err(p_addr, p_we);
            if (!p_we) mem_rdata = mem[p_addr[13:2]];
            else if (!mem_rsp_err) mem[p_addr[13:2]] = p_data;
            pend = 0;
         end else cnt--;
      end
      if (rst_n && mem_req) begin
         check(!pend, "R10 request while one outstanding", 32'd1, 32'd0);
         if (q_addr.size() == 0)
            check(1'b0, "R6 unexpected request", mem_addr, 32'hFFFF_FFFF);
         else begin
            logic [31:0] ea, ed;
            logic ew;
            ea = q_addr.pop_front();
            ew = q_we.pop_front();
            ed = q_data.pop_front();
            check(mem_addr == ea, "R1 R3 request address", mem_addr, ea);
            check(mem_we == ew, "R3 request direction", 32'(mem_we), 32'(ew));
            if (ew) check(mem_wdata == ed, "R3 write data", mem_wdata, ed);
         end
         pend = 1;
         cnt = lat;
         p_addr = mem_addr;
         p_we = mem_we;
         p_data = mem_wdata;
      end
   end

   task automatic push(input logic [31:0] a, input logic w, input logic [31:0] d);
      q_addr.push_back(a);
      q_we.push_back(w);
      q_data.push_back(d);
   endtask

   // reference walk of the descriptor list
   task automatic build(input logic [31:0] base, output logic [4:0] st);
      logic [31:0] p, w0, w1, w2, s, d;
      p = base;
      st = '0;
      forever begin
         push(p, 1'b0, '0);
         if (is_err(p, 1'b0)) begin st[4] = 1'b1; return; end
         w0 = mem[p[13:2]]; p += 4;
         push(p, 1'b0, '0);
         if (is_err(p, 1'b0)) begin st[4] = 1'b1; return; end
         w1 = mem[p[13:2]]; p += 4;
         push(p, 1'b0, '0);
         if (is_err(p, 1'b0)) begin st[4] = 1'b1; return; end
         w2 = mem[p[13:2]]; p += 4;
         if (w2[17:0] == 18'd0 || w2[7:0] != 8'd0) begin st[4] = 1'b1; return; end
         for (int k = 0; k < int'(w2[17:2]); k++) begin
            s = w0 + 32'(4 * k);
            d = w1 + 32'(4 * k);
            push(s, 1'b0, '0);
            if (is_err(s, 1'b0)) begin st[2] = 1'b1; return; end
            push(d, 1'b1, mem[s[13:2]]);
            if (is_err(d, 1'b1)) begin st[3] = 1'b1; return; end
         end
         if (w2[31]) begin st[1:0] = 2'b11; return; end
      end
   endtask

   task automatic run(input logic [31:0] base, input logic [4:0] prior, input bit dup, input string tag);
      logic [4:0] st, exp;
      int t;
      build(base, st);
      exp = prior | st;
      @(negedge clk); sw_base = base; sw_start = 1'b1;
      @(negedge clk); sw_start = 1'b0;
      check(busy, "R7 start from idle", 32'(busy), 32'd1);
      if (dup) begin
         repeat (7) @(negedge clk);
         sw_base = 32'h300; sw_start = 1'b1;   // R7: ignored while busy
         @(negedge clk); sw_start = 1'b0;
      end
      t = 0;
      while (busy && t < 20000) begin @(negedge clk); t++; end
      repeat (4) @(negedge clk);
      check(!busy, "R4 engine returns idle", 32'(busy), 32'd0);
      check(q_addr.size() == 0, "R3 all expected requests issued", 32'(q_addr.size()), 32'd0);
      check(status == exp, tag, 32'(status), 32'(exp));
      check(irq == (irq_en && exp != 0), "R9 irq after run", 32'(irq), 32'(irq_en && exp != 0));
   endtask

   task automatic clear(input logic [4:0] m, input logic [4:0] exp);
      @(negedge clk); sw_clr = 1'b1; sw_clr_mask = m;
      @(negedge clk); sw_clr = 1'b0; sw_clr_mask = '0;
      check(status == exp, "R8 write-one-to-clear", 32'(status), 32'(exp));
      check(irq == (irq_en && exp != 0), "R9 irq after clear", 32'(irq), 32'(irq_en && exp != 0));
   endtask

   task automatic desc(input logic [31:0] a, input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
      mem[a[13:2]] = s;
      mem[a[13:2] + 1] = d;
      mem[a[13:2] + 2] = c;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog expired", 32'd0, 32'd1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = (32'(i) * 32'h0101_0107) ^ 32'hA5C3_0000;
      desc(32'h100, 32'h1000, 32'h2000, 32'h8000_0100);
      desc(32'h200, 32'h1400, 32'h2800, 32'h7FFC_0200);   // R2 reserved bits set
      desc(32'h20C, 32'h1800, 32'h3000, 32'h8000_0100);
      desc(32'h300, 32'h1000, 32'h2400, 32'h8000_0104);
      desc(32'h340, 32'h1000, 32'h2400, 32'h8000_0000);
      desc(32'h380, 32'h1000, 32'h2400, 32'h8000_0100);
      desc(32'h3C0, 32'h1000, 32'h2400, 32'h8000_0100);
      desc(32'h400, 32'h1000, 32'h2400, 32'h8000_0100);

      repeat (3) @(negedge clk);
      // R11 reset state
      check(!busy, "R11 busy after reset", 32'(busy), 32'd0);
      check(status == 5'd0, "R11 status after reset", 32'(status), 32'd0);
      check(!irq, "R11 irq after reset", 32'(irq), 32'd0);
      check(!mem_req, "R11 no request in reset", 32'(mem_req), 32'd0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);

      lat = 0;
      run(32'h100, 5'h00, 1'b0, "R4 single final descriptor");
      clear(5'h03, 5'h00);

      lat = 2;
      run(32'h200, 5'h00, 1'b1, "R1 R2 R7 chained list");

      lat = 1;
      run(32'h300, 5'h03, 1'b0, "R5 count not multiple of 256");
      @(negedge clk); irq_en = 1'b0;
      #1 check(!irq, "R9 irq masked", 32'(irq), 32'd0);
      @(negedge clk); irq_en = 1'b1;
      #1 check(irq, "R9 irq enabled", 32'(irq), 32'd1);
      clear(5'h10, 5'h03);
      clear(5'h1F, 5'h00);

      run(32'h340, 5'h00, 1'b0, "R5 zero count");
      clear(5'h10, 5'h00);

      err_on = 1; err_a = 32'h1040; err_w = 1'b0;
      lat = 3;
      run(32'h380, 5'h00, 1'b0, "R6 data read error");
      err_a = 32'h2480; err_w = 1'b1;
      lat = 0;
      run(32'h3C0, 5'h04, 1'b0, "R6 data write error");
      clear(5'h1F, 5'h00);

      err_a = 32'h404; err_w = 1'b0;
      run(32'h400, 5'h00, 1'b0, "R5 descriptor fetch error");
      err_on = 0;
      clear(5'h1F, 5'h00);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule